// File: doc/BRIEF.md
# I2C Controller Transfer Sequencer

This block runs one complete I2C transaction as the only controller on the bus. A start pulse, together with a flag word, picks one of four transaction shapes: a plain write, a plain read, a write followed by a read after a repeated START, or a write drawn from two buffers back to back. The target address may be 7 or 10 bits wide. The block works out the order of START, address bytes, data bytes, repeated START and STOP. It hands each step to a separate bit engine as a one-cycle command, then waits until the engine reports the result of that step.

Bytes to be written come from a byte stream that the block consumes one byte per write command. Bytes that are read leave on a one-cycle strobe. A result code reads "in progress" for the whole transaction. When the transaction ends, the code changes to the outcome: completed, NACK received, bus error, arbitration lost, usage fault or internal fault. Arbitration loss is final and the block does not retry.

Top module: `i2c_xfer_seq`

## Requirements
- R1: After reset `status` is 1 (done), `busy` is 0 and `cmd_valid` is 0.
- R2: Flag bits 0 to 3 select write, read, write-then-read and two-buffer write respectively. A start with a number of these bits other than exactly one is rejected with `status`=5 (usage fault). A start whose read buffer length is zero is also rejected with `status`=5. The read buffer is `len0` for read and `len1` for write-then-read. A rejected start issues no command and leaves `busy` low.
- R3: Write (flag 0x01) issues START, the write address byte(s), then `len0` write commands, each carrying the next `wr_data` byte with `wr_take` high, then STOP. A zero `len0` gives START, address, STOP.
- R4: Read (flag 0x02, 7-bit) issues START, the address byte {addr[6:0],1}, then `len0` read commands, then STOP. Every read command except the last has `cmd_nack`=0, and the last has `cmd_nack`=1. Each completed read puts `be_rdata` on `rd_data` with `rd_valid` high for one cycle, one cycle after `be_done`.
- R5: Write-then-read (flag 0x04) issues START, the write address, `len0` data bytes, a repeated START, the read address byte, `len1` reads and STOP.
- R6: Two-buffer write (flag 0x08) issues START, the write address, then `len0`+`len1` data bytes with no repeated START between the buffers, then STOP.
- R7: Flag bit 4 selects a 10-bit address. The first address byte is {5'b11110, addr[9:8], rw} and the second is addr[7:0]. After a repeated START only the first byte is sent again, with rw=1. A 10-bit plain read sends both bytes with rw=0, then a repeated START, then the first byte with rw=1, then the reads.
- R8: A `be_nack` reported with `be_done` on an address byte or a written data byte ends the transfer. The next command is STOP, and `status` becomes 2 once the STOP completes.
- R9: `be_arblost` while busy ends the transfer at the next clock edge with `status`=4 and no further command, including no STOP.
- R10: `be_buserr` while busy ends the transfer at the next clock edge with `status`=3 and no further command.
- R11: `status` is 0 exactly while `busy` is high. A transfer without error shows `status`=1 after its STOP completes. A start pulse while busy is ignored.
- R12: Command codes on `cmd_op` are 1 START, 2 repeated START, 3 write byte, 4 read byte and 5 STOP. `cmd_valid` is high for one cycle per command, and the next command follows only after `be_done` for the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (used when idle) |
| flags | input | 5 | Sequence select bits [3:0], 10-bit address bit [4] |
| taddr | input | 10 | Target address (7-bit mode uses [6:0]) |
| len0 | input | LEN_W | Byte count of buffer 0 |
| len1 | input | LEN_W | Byte count of buffer 1 |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | `wr_data` consumed this cycle |
| cmd_valid | output | 1 | Command strobe to the bit engine |
| cmd_op | output | 3 | Command code |
| cmd_byte | output | 8 | Byte for a write command |
| cmd_nack | output | 1 | Answer a read with NACK |
| be_done | input | 1 | Bit engine finished the command |
| be_nack | input | 1 | Target did not acknowledge (with `be_done`) |
| be_rdata | input | 8 | Received byte (with `be_done`) |
| be_arblost | input | 1 | Arbitration lost |
| be_buserr | input | 1 | Misplaced START or STOP seen |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| busy | output | 1 | Transaction in progress |
| status | output | 3 | 0 busy, 1 done, 2 NACK, 3 bus error, 4 arbitration lost, 5 usage fault, 6 internal fault |

## Verification
The assertions assume a well-behaved bit engine. It raises `be_done` only after a command and only once for it. It never raises arbitration loss and bus error in the same cycle. It keeps `wr_data` valid whenever a write command may be issued. The bench's engine model meets these assumptions: it counts a delay from each observed command and sends exactly one response, it injects only one error kind per transaction, and it presents the head of its write queue at all times. Usage-fault starts and start pulses sent mid-transfer are the only stimuli that break the normal order, and both are legal inputs.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_STOP   = 3'd5
  } bus_op_e;

  typedef enum logic [2:0] {
    RES_BUSY    = 3'd0,
    RES_DONE    = 3'd1,
    RES_NACK    = 3'd2,
    RES_BUSERR  = 3'd3,
    RES_ARBLOST = 3'd4,
    RES_USAGE   = 3'd5,
    RES_SWFAULT = 3'd6
  } result_e;

  localparam int FLG_WRITE = 0;
  localparam int FLG_READ  = 1;
  localparam int FLG_WRRD  = 2;
  localparam int FLG_WRWR  = 3;
  localparam int FLG_TEN   = 4;
  localparam int FLG_W     = 5;

  // First (or only) address byte for a given direction bit.
  function automatic logic [7:0] hdr_byte(input logic ten, input logic [9:0] a,
                                          input logic rw);
    return ten ? {5'b11110, a[9:8], rw} : {a[6:0], rw};
  endfunction

endpackage

// File: rtl/i2c_seq_plan.sv
module i2c_seq_plan
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic [FLG_W-1:0] flags,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  output logic             ok,
  output logic             ten,
  output logic             rd_first,
  output logic             rs,
  output logic [LEN_W:0]   wtot,
  output logic [LEN_W-1:0] rtot
);

  logic need_rd;
  logic one_seq;

  always_comb begin
    ten      = flags[FLG_TEN];
    rd_first = 1'b0;
    rs       = 1'b0;
    wtot     = '0;
    rtot     = '0;
    need_rd  = 1'b0;
    one_seq  = $onehot(flags[FLG_WRWR:FLG_WRITE]);
    case (flags[FLG_WRWR:FLG_WRITE])
      4'b0001: wtot = {1'b0, len0};
      4'b0010: begin
        rtot    = len0;
        need_rd = 1'b1;
        // 10-bit read addresses in write direction, then turns around
        if (flags[FLG_TEN]) rs = 1'b1;
        else                rd_first = 1'b1;
      end
      4'b0100: begin
        wtot    = {1'b0, len0};
        rtot    = len1;
        rs      = 1'b1;
        need_rd = 1'b1;
      end
      4'b1000: wtot = {1'b0, len0} + {1'b0, len1};
      default: ;
    endcase
    ok = one_seq && !(need_rd && (rtot == '0));
  end

endmodule

// File: rtl/i2c_seq_addr.sv
module i2c_seq_addr
  import i2c_seq_pkg::*;
(
  input  logic       ten,
  input  logic [9:0] addr,
  input  logic       rd_first,
  output logic [7:0] hdr_first,
  output logic [7:0] hdr_rd,
  output logic [7:0] lo_byte
);

  assign hdr_first = hdr_byte(ten, addr, rd_first);
  assign hdr_rd    = hdr_byte(ten, addr, 1'b1);
  assign lo_byte   = addr[7:0];

endmodule

// File: rtl/i2c_seq_fsm.sv
module i2c_seq_fsm
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             plan_ok,
  input  logic             p_ten,
  input  logic             p_rdfirst,
  input  logic             p_rs,
  input  logic [LEN_W:0]   p_wtot,
  input  logic [LEN_W-1:0] p_rtot,
  input  logic [9:0]       taddr,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  input  logic             be_done,
  input  logic             be_nack,
  input  logic [7:0]       be_rdata,
  input  logic             be_arblost,
  input  logic             be_buserr,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic [2:0]       status
);

  typedef enum logic [3:0] {
    S_IDLE, S_START, S_AHI, S_ALO, S_WDAT, S_RSTART, S_ARD, S_RDAT, S_STOP
  } seq_state_e;

  seq_state_e       state_q;
  logic             wait_q;
  logic             ten_q, rdf_q, rs_q;
  logic [9:0]       addr_q;
  logic [LEN_W:0]   wleft_q;
  logic [LEN_W-1:0] rleft_q;
  result_e          pend_q, status_q;
  logic             rdv_q;
  logic [7:0]       rdd_q;

  // named internal events
  logic       step_done;
  logic       last_rd;
  seq_state_e after_addr;
  seq_state_e after_wr;
  logic [7:0] hdr_first, hdr_rd, lo_byte;

  i2c_seq_addr u_addr (
    .ten      (ten_q),
    .addr     (addr_q),
    .rd_first (rdf_q),
    .hdr_first(hdr_first),
    .hdr_rd   (hdr_rd),
    .lo_byte  (lo_byte)
  );

  assign busy      = (state_q != S_IDLE);
  assign step_done = busy && wait_q && be_done;
  assign last_rd   = (rleft_q == LEN_W'(1));
  assign after_wr  = rs_q ? S_RSTART : S_STOP;

  always_comb begin
    if (rdf_q)                after_addr = S_RDAT;
    else if (wleft_q != '0)   after_addr = S_WDAT;
    else                      after_addr = after_wr;
  end

  always_comb begin
    cmd_valid = busy && !wait_q;
    cmd_op    = OP_NONE;
    cmd_byte  = 8'h00;
    cmd_nack  = 1'b0;
    wr_take   = 1'b0;
    case (state_q)
      S_START:  cmd_op = OP_START;
      S_AHI:    begin cmd_op = OP_WRITE; cmd_byte = hdr_first; end
      S_ALO:    begin cmd_op = OP_WRITE; cmd_byte = lo_byte;   end
      S_WDAT:   begin
        cmd_op   = OP_WRITE;
        cmd_byte = wr_data;
        wr_take  = cmd_valid;
      end
      S_RSTART: cmd_op = OP_RSTART;
      S_ARD:    begin cmd_op = OP_WRITE; cmd_byte = hdr_rd; end
      S_RDAT:   begin cmd_op = OP_READ; cmd_nack = last_rd; end
      S_STOP:   cmd_op = OP_STOP;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      wait_q   <= 1'b0;
      ten_q    <= 1'b0;
      rdf_q    <= 1'b0;
      rs_q     <= 1'b0;
      addr_q   <= '0;
      wleft_q  <= '0;
      rleft_q  <= '0;
      pend_q   <= RES_DONE;
      status_q <= RES_DONE;
      rdv_q    <= 1'b0;
      rdd_q    <= 8'h00;
    end else begin
      rdv_q <= 1'b0;
      if (state_q == S_IDLE) begin
        if (start) begin
          if (plan_ok) begin
            state_q  <= S_START;
            wait_q   <= 1'b0;
            ten_q    <= p_ten;
            rdf_q    <= p_rdfirst;
            rs_q     <= p_rs;
            addr_q   <= taddr;
            wleft_q  <= p_wtot;
            rleft_q  <= p_rtot;
            pend_q   <= RES_DONE;
            status_q <= RES_BUSY;
          end else begin
            status_q <= RES_USAGE;
          end
        end
      end else if (be_buserr) begin
        state_q  <= S_IDLE;
        status_q <= RES_BUSERR;
      end else if (be_arblost) begin
        state_q  <= S_IDLE;
        status_q <= RES_ARBLOST;
      end else if (!wait_q) begin
        wait_q <= 1'b1;
      end else if (step_done) begin
        wait_q <= 1'b0;
        case (state_q)
          S_START:  state_q <= S_AHI;
          S_AHI, S_ALO: begin
            if (be_nack) begin
              state_q <= S_STOP;
              pend_q  <= RES_NACK;
            end else if (state_q == S_AHI && ten_q) begin
              state_q <= S_ALO;
            end else begin
              state_q <= after_addr;
            end
          end
          S_WDAT: begin
            if (be_nack) begin
              state_q <= S_STOP;
              pend_q  <= RES_NACK;
            end else begin
              wleft_q <= wleft_q - 1'b1;
              if (wleft_q == (LEN_W+1)'(1)) state_q <= after_wr;
            end
          end
          S_RSTART: state_q <= S_ARD;
          S_ARD: begin
            if (be_nack) begin
              state_q <= S_STOP;
              pend_q  <= RES_NACK;
            end else begin
              state_q <= S_RDAT;
            end
          end
          S_RDAT: begin
            rdv_q   <= 1'b1;
            rdd_q   <= be_rdata;
            rleft_q <= rleft_q - 1'b1;
            if (last_rd) state_q <= S_STOP;
          end
          S_STOP: begin
            state_q  <= S_IDLE;
            status_q <= pend_q;
          end
          default: begin
            state_q  <= S_IDLE;
            status_q <= RES_SWFAULT;
          end
        endcase
      end
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
  assign status   = status_q;

  AST_BUSY_INPROG: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (status_q == RES_BUSY)); // R11
  AST_OPEN_WITH_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cmd_valid && cmd_op == OP_START)); // R12
  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R12
  AST_TAKE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (cmd_valid && cmd_op == OP_WRITE)); // R3
  AST_ARB_NO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && be_arblost && !be_buserr) |=> (!busy && status_q == RES_ARBLOST && !cmd_valid)); // R9
  AST_BUSERR_END: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && be_buserr) |=> (!busy && status_q == RES_BUSERR)); // R10
  AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && status_q == RES_DONE) |-> ($past(state_q) == S_STOP)); // R11

endmodule

// File: rtl/i2c_xfer_seq.sv
module i2c_xfer_seq
  import i2c_seq_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [4:0]       flags,
  input  logic [9:0]       taddr,
  input  logic [LEN_W-1:0] len0,
  input  logic [LEN_W-1:0] len1,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic             cmd_valid,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_byte,
  output logic             cmd_nack,
  input  logic             be_done,
  input  logic             be_nack,
  input  logic [7:0]       be_rdata,
  input  logic             be_arblost,
  input  logic             be_buserr,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic [2:0]       status
);

  logic             plan_ok, p_ten, p_rdfirst, p_rs;
  logic [LEN_W:0]   p_wtot;
  logic [LEN_W-1:0] p_rtot;

  i2c_seq_plan #(.LEN_W(LEN_W)) u_plan (
    .flags   (flags),
    .len0    (len0),
    .len1    (len1),
    .ok      (plan_ok),
    .ten     (p_ten),
    .rd_first(p_rdfirst),
    .rs      (p_rs),
    .wtot    (p_wtot),
    .rtot    (p_rtot)
  );

  i2c_seq_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .plan_ok   (plan_ok),
    .p_ten     (p_ten),
    .p_rdfirst (p_rdfirst),
    .p_rs      (p_rs),
    .p_wtot    (p_wtot),
    .p_rtot    (p_rtot),
    .taddr     (taddr),
    .wr_data   (wr_data),
    .wr_take   (wr_take),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_byte  (cmd_byte),
    .cmd_nack  (cmd_nack),
    .be_done   (be_done),
    .be_nack   (be_nack),
    .be_rdata  (be_rdata),
    .be_arblost(be_arblost),
    .be_buserr (be_buserr),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .busy      (busy),
    .status    (status)
  );

  AST_USAGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !plan_ok) |=> (!cmd_valid && !busy && status == 3'(RES_USAGE))); // R2

endmodule

// File: tb/sim_i2c_xfer_seq.sv
`timescale 1ns/100ps
module sim_i2c_xfer_seq;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] flags = 5'd0;
  logic [9:0] taddr;
  logic [7:0] len0, len1;
  logic [7:0] wr_data = 8'd0;
  logic       wr_take, cmd_valid, cmd_nack, rd_valid, busy;
  logic [2:0] cmd_op, status;
  logic [7:0] cmd_byte, rd_data;
  logic       be_done = 1'b0, be_nack = 1'b0, be_arblost = 1'b0, be_buserr = 1'b0;
  logic [7:0] be_rdata = 8'd0;

  always #2.5 clk = ~clk;

  i2c_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .flags(flags), .taddr(taddr),
    .len0(len0), .len1(len1), .wr_data(wr_data), .wr_take(wr_take),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_byte(cmd_byte), .cmd_nack(cmd_nack),
    .be_done(be_done), .be_nack(be_nack), .be_rdata(be_rdata),
    .be_arblost(be_arblost), .be_buserr(be_buserr),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy), .status(status)
  );

  int nchk = 0, nerr = 0;
  int exp_cmd[$];
  logic [7:0] wq[$];
  logic [7:0] exp_rd[$];

  // test configuration, written by the stimulus process
  logic [4:0] cur_flags = 5'd0;
  int dly = 1, nack_at = -1, arb_at = -1, bus_at = -1, glitch_at = -1;
  string tag = "R1";
  int go_cnt = 0;

  // engine / model state, written by the clocked model
  int go_seen = 0, done_cnt = 0, cyc = 0;
  int exp_status = 1;
  int upd_pend = 0, upd_code = 0, upd_fin = 0;
  int rsp_cnt = 0, rsp_kind = 0, rsp_op = 0, cmd_idx = 0, rd_n = 0, nack_hit = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int enc(input int op, input int nk, input int b);
    return op * 512 + nk * 256 + b;
  endfunction

  // clocked reference model and bit-engine model
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (cyc > 150000) begin
        nchk++; nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("  Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
      end
      if (upd_pend != 0) exp_status = upd_code;
      chk(status == exp_status[2:0], tag, "R11 status", status, exp_status);
      chk(busy == (exp_status == 0), tag, "R11 busy", busy, exp_status == 0);
      if (rd_valid) begin
        if (exp_rd.size() == 0) chk(0, tag, "R4 unexpected rd_valid", rd_data, -1);
        else chk(rd_data == exp_rd.pop_front(), tag, "R4 rd_data", rd_data, 0);
      end
      if (start) begin start = 1'b0; flags = cur_flags; end
      be_done = 1'b0; be_nack = 1'b0; be_arblost = 1'b0; be_buserr = 1'b0;
      if (rsp_cnt > 0) begin
        rsp_cnt--;
        if (rsp_cnt == 0) begin
          upd_code = -1;
          if (rsp_kind == 2) begin be_arblost = 1'b1; upd_code = 4; end
          else if (rsp_kind == 3) begin be_buserr = 1'b1; upd_code = 3; end
          else begin
            be_done = 1'b1;
            if (rsp_kind == 1) begin be_nack = 1'b1; nack_hit = 1; end
            if (rsp_op == 4) begin
              be_rdata = 8'hC0 + 8'(rd_n);
              exp_rd.push_back(8'hC0 + 8'(rd_n));
              rd_n++;
            end
            if (rsp_op == 5) upd_code = nack_hit ? 2 : 1;
          end
        end
      end
      if (cmd_valid) begin
        int obs;
        obs = enc(int'(cmd_op), (cmd_op == 3'd4) ? int'(cmd_nack) : 0,
                  (cmd_op == 3'd3) ? int'(cmd_byte) : 0);
        if (exp_cmd.size() == 0) chk(0, tag, "R12 unexpected command", obs, -1);
        else begin
          int e;
          e = exp_cmd.pop_front();
          chk(obs == e, tag, "R12 command", obs, e);
        end
        rsp_op = int'(cmd_op);
        if (cmd_idx == arb_at) rsp_kind = 2;
        else if (cmd_idx == bus_at) rsp_kind = 3;
        else if (cmd_idx == nack_at) rsp_kind = 1;
        else rsp_kind = 0;
        rsp_cnt = dly;
        if (cmd_idx == glitch_at) begin start = 1'b1; flags = 5'd0; end
        if (wr_take && wq.size() != 0) void'(wq.pop_front());
        cmd_idx++;
      end
      if (upd_pend != 0) begin
        upd_pend = 0;
        if (upd_fin != 0) done_cnt++;
      end
      if (upd_code >= 0 && rsp_cnt == 0 && (be_done || be_arblost || be_buserr)) begin
        upd_pend = 1; upd_fin = 1;
      end
      upd_code = (upd_pend != 0) ? upd_code : -1;
      if (go_cnt != go_seen) begin
        int rl;
        bit ok;
        go_seen = go_cnt;
        flags = cur_flags;
        start = 1'b1;
        cmd_idx = 0; rd_n = 0; nack_hit = 0;
        rl = (cur_flags[3:0] == 4'b0010) ? int'(len0) : (cur_flags[3:0] == 4'b0100) ? int'(len1) : 1;
        ok = ($countones(cur_flags[3:0]) == 1) && (rl != 0);
        upd_pend = 1;
        upd_code = ok ? 0 : 5;
        upd_fin = ok ? 0 : 1;
      end
      wr_data = (wq.size() != 0) ? wq[0] : 8'd0;
    end
  end

  function automatic void push_data(input int n);
    for (int i = 0; i < n; i++) begin
      logic [7:0] b;
      b = 8'h30 + 8'(wq.size());
      wq.push_back(b);
      exp_cmd.push_back(enc(3, 0, int'(b)));
    end
  endfunction

  function automatic void push_reads(input int n);
    for (int i = 0; i < n; i++) exp_cmd.push_back(enc(4, (i == n - 1) ? 1 : 0, 0));
  endfunction

  task automatic run(input string t, input logic [4:0] f, input logic [9:0] a,
                     input int l0, input int l1, input int d,
                     input int nk, input int arb, input int be, input int gl);
    int hw, hr, lo, n0, fin_code;
    bit ten;
    exp_cmd.delete(); wq.delete(); exp_rd.delete();
    tag = t; cur_flags = f; taddr = a; len0 = 8'(l0); len1 = 8'(l1);
    dly = d; nack_at = nk; arb_at = arb; bus_at = be; glitch_at = gl;
    ten = f[4];
    hw = ten ? (8'hF0 | ((int'(a) >> 8) & 3) * 2) : (int'(a) & 8'h7F) * 2;
    hr = hw + 1;
    lo = int'(a) & 8'hFF;
    fin_code = 1;
    if ($countones(f[3:0]) != 1 || (f[3:0] == 4'b0010 && l0 == 0) || (f[3:0] == 4'b0100 && l1 == 0))
      fin_code = 5;
    else begin
      exp_cmd.push_back(enc(1, 0, 0));
      if (f[3:0] == 4'b0010 && !ten) begin
        exp_cmd.push_back(enc(3, 0, hr));
        push_reads(l0);
      end else begin
        exp_cmd.push_back(enc(3, 0, hw));
        if (ten) exp_cmd.push_back(enc(3, 0, lo));
        if (f[3:0] == 4'b0001 || f[3:0] == 4'b0100) push_data(l0);
        if (f[3:0] == 4'b1000) push_data(l0 + l1);
        if (f[3:0] == 4'b0100 || f[3:0] == 4'b0010) begin
          exp_cmd.push_back(enc(2, 0, 0));
          exp_cmd.push_back(enc(3, 0, hr));
          push_reads(f[3:0] == 4'b0010 ? l0 : l1);
        end
      end
      exp_cmd.push_back(enc(5, 0, 0));
      if (nk >= 0) begin
        while (exp_cmd.size() > nk + 1) void'(exp_cmd.pop_back());
        exp_cmd.push_back(enc(5, 0, 0));
        fin_code = 2;
      end
      if (arb >= 0 || be >= 0) begin
        while (exp_cmd.size() > ((arb >= 0) ? arb : be) + 1) void'(exp_cmd.pop_back());
        fin_code = (arb >= 0) ? 4 : 3;
      end
    end
    n0 = done_cnt;
    @(posedge clk); #1;
    go_cnt++;
    wait (done_cnt != n0);
    repeat (3) @(negedge clk);
    #0.5;
    chk(status == 3'(fin_code), t, "final status", status, fin_code);
    chk(busy == 1'b0, t, "idle at end", busy, 0);
    chk(exp_cmd.size() == 0, t, "R12 missing commands", exp_cmd.size(), 0);
    chk(exp_rd.size() == 0, t, "R4 missing read bytes", exp_rd.size(), 0);
  endtask

  initial begin
    taddr = 10'd0; len0 = 8'd0; len1 = 8'd0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk); #0.5;
    chk(status == 3'd1, "R1", "reset status", status, 1);
    chk(busy == 1'b0, "R1", "reset busy", busy, 0);
    chk(cmd_valid == 1'b0, "R1", "reset cmd_valid", cmd_valid, 0);

    run("R3",  5'h01, 10'h02A, 3, 0, 1, -1, -1, -1, -1);
    run("R3",  5'h01, 10'h011, 0, 0, 2, -1, -1, -1, -1);
    run("R4",  5'h02, 10'h055, 4, 0, 2, -1, -1, -1, -1);
    run("R4",  5'h02, 10'h07F, 1, 0, 1, -1, -1, -1, -1);
    run("R5",  5'h04, 10'h033, 2, 3, 1, -1, -1, -1, 2);
    run("R6",  5'h08, 10'h048, 2, 3, 3, -1, -1, -1, -1);
    run("R7",  5'h11, 10'h2C5, 1, 0, 1, -1, -1, -1, -1);
    run("R7",  5'h14, 10'h17E, 1, 2, 2, -1, -1, -1, -1);
    run("R7",  5'h12, 10'h3FF, 2, 0, 1, -1, -1, -1, -1);
    run("R7",  5'h18, 10'h101, 1, 1, 1, -1, -1, -1, -1);
    run("R2",  5'h00, 10'h010, 1, 1, 1, -1, -1, -1, -1);
    run("R2",  5'h05, 10'h010, 1, 1, 1, -1, -1, -1, -1);
    run("R2",  5'h02, 10'h010, 0, 1, 1, -1, -1, -1, -1);
    run("R2",  5'h04, 10'h010, 2, 0, 1, -1, -1, -1, -1);
    run("R8",  5'h01, 10'h020, 3, 0, 1, 1, -1, -1, -1);
    run("R8",  5'h01, 10'h020, 3, 0, 2, 3, -1, -1, -1);
    run("R8",  5'h04, 10'h021, 1, 2, 1, 4, -1, -1, -1);
    run("R8",  5'h11, 10'h1A0, 2, 0, 1, 2, -1, -1, -1);
    run("R9",  5'h02, 10'h044, 3, 0, 2, -1, 2, -1, -1);
    run("R9",  5'h08, 10'h044, 1, 1, 1, -1, 4, -1, -1);
    run("R10", 5'h01, 10'h066, 2, 0, 1, -1, -1, 0, -1);
    run("R10", 5'h04, 10'h066, 1, 1, 2, -1, -1, 3, -1);
    run("R11", 5'h01, 10'h05A, 2, 0, 1, -1, -1, -1, 1);

    $display("  Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule